// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from up to 64 sources and presents a single request line with a source number to a small processor core. A rising edge on any request input is caught in a per-source pending flag. Each source also has a mask bit and a three-bit priority. Software reaches all of this through a byte-wide register bus. There is one control byte per source. A packed mask window reaches the same mask bits eight at a time.

An in-service register keeps one bit per priority level. When the core acknowledges a request, the controller clears that source's pending flag and marks its level as in service. Requests at that level or any less urgent level are then held back until software writes the end-of-interrupt strobe. That strobe retires the most urgent level still in service. A more urgent source can therefore preempt a handler that is already running, and an equal or less urgent source cannot.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source is masked, has priority 7 and has no pending flag. The in-service register is zero and `int_req` is low, so a control byte reads 0x47 and a mask-window byte reads 0xFF.
- R2: The control byte of source n sits at offset 0x110 + 2n. Bit 7 is the pending flag, bit 6 is the mask (1 = disabled) and bits 2:0 are the priority (0 = most urgent). Bits 5:3 read as zero, and writing the byte loads the mask and the priority.
- R3: Mask-window byte 0x100 + (n >> 3), bit (n & 7), is the mask bit of source n. It is the same storage as bit 6 of that source's control byte, so a write through either path is visible through both.
- R4: A rising edge on `irq_i[n]` sets the pending flag of source n even while the source is masked. A masked pending source makes no request, and it is requested once its mask is cleared.
- R5: Writing a control byte with bit 7 = 0 clears that source's pending flag, and writing bit 7 = 1 never sets it. If a request edge arrives in the same cycle as the clear, the flag stays set.
- R6: Among the eligible sources, the one with the lowest priority value is presented. Sources with equal priority go to the lower source number.
- R7: A source is eligible only if it is pending, unmasked, and no in-service bit is set at its own level or at any more urgent (lower-numbered) level.
- R8: An acknowledge (`int_ack` while `int_req` is high) clears the pending flag of source `int_id` and sets in-service bit `prio[int_id]`. It also drops `int_req` in the following cycle.
- R9: A write of any data to offset 0x1FC is the end-of-interrupt strobe. It clears the lowest-numbered set bit of the in-service register. When it coincides with an acknowledge, the bit is chosen from the old value and the acknowledged level is then set.
- R10: The in-service register reads at offset 0x1FA, and bus writes to that offset leave it unchanged.
- R11: `int_req` and `int_id` are registered. They reflect the arbitration one clock after the pending, mask, priority or in-service state changes. A request edge therefore reaches `int_req` on the second rising clock edge after the input goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Request inputs, one per source, rising-edge sensitive |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| int_ack | input | 1 | Acknowledge from the core |
| int_req | output | 1 | Interrupt request to the core |
| int_id | output | ID_W | Source number being requested |

## Verification
Two pairs of actions can land in the same clock edge. The first pair is a software clear of a pending flag and a fresh request edge on that same source. The second pair is a core acknowledge and an end-of-interrupt write. The bench provokes each pair by driving both stimuli on the same falling edge. For the first pair it reads back the control byte and expects the pending flag to still be set. For the second it expects the in-service byte to have lost its old most urgent bit and gained the newly acknowledged level (0x10 becoming 0x02).

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int PRIO_W    = 3;
   localparam int NLEVELS   = 1 << PRIO_W;
   localparam int MASK_OFS  = 'h100;
   localparam int CTRL_OFS  = 'h110;
   localparam int ISR_OFS   = 'h1FA;
   localparam int EOI_OFS   = 'h1FC;
   localparam int PEND_BIT  = 7;
   localparam int MASK_BIT  = 6;
   localparam int MAX_SRC   = 64;
   typedef logic [PRIO_W-1:0]  prio_t;
   typedef logic [NLEVELS-1:0] lvl_vec_t;
endpackage

// File: rtl/prio_irq_srcbank.sv
module prio_irq_srcbank
   import prio_irq_pkg::*;
#(
   parameter int NSRC   = 64,
   localparam int NBYTES = NSRC / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_i,
   input  logic [NSRC-1:0]   ctrl_we,
   input  logic [NBYTES-1:0] win_we,
   input  logic [7:0]        wdata,
   input  logic [NSRC-1:0]   ack_clr,
   output logic [NSRC-1:0]   pend,
   output logic [NSRC-1:0]   mask,
   output prio_t             prio [NSRC]
);
   for (genvar n = 0; n < NSRC; n++) begin : g_src
      logic  irq_q, rise, clr;
      logic  pend_q, mask_q;
      prio_t prio_q;

      assign rise = irq_i[n] & ~irq_q;
      assign clr  = (ctrl_we[n] & ~wdata[PEND_BIT]) | ack_clr[n];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
            mask_q <= 1'b1;
            prio_q <= '1;
         end else begin
            irq_q  <= irq_i[n];
            pend_q <= rise | (pend_q & ~clr);
            if (ctrl_we[n]) begin
               mask_q <= wdata[MASK_BIT];
               prio_q <= wdata[PRIO_W-1:0];
            end else if (win_we[n/8]) begin
               mask_q <= wdata[n%8];
            end
         end
      end

      assign pend[n] = pend_q;
      assign mask[n] = mask_q;
      assign prio[n] = prio_q;

      assert_edge_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_i[n] && !irq_q) |=> pend_q);
      assert_swclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_we[n] && !wdata[PEND_BIT] && !rise) |=> !pend_q);
   end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
   import prio_irq_pkg::*;
#(
   parameter int NSRC = 64,
   localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0] pend,
   input  logic [NSRC-1:0] mask,
   input  prio_t           prio [NSRC],
   input  lvl_vec_t        ispr,
   output logic            found,
   output logic [ID_W-1:0] sel_id
);
   prio_t best;

   always_comb begin
      found  = 1'b0;
      sel_id = '0;
      best   = '1;
      for (int i = 0; i < NSRC; i++) begin
         logic     elig;
         lvl_vec_t blockers;
         blockers = lvl_vec_t'({NLEVELS{1'b1}}) >> (prio_t'(NLEVELS-1) - prio[i]);
         elig = pend[i] & ~mask[i] & ((ispr & blockers) == '0);
         if (elig && (!found || prio[i] < best)) begin
            found  = 1'b1;
            best   = prio[i];
            sel_id = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_isr.sv
module prio_irq_isr
   import prio_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_en,
   input  prio_t    set_lvl,
   input  logic     eoi,
   output lvl_vec_t ispr
);
   lvl_vec_t isr_q, lowbit, setbit;

   assign lowbit = isr_q & (~isr_q + lvl_vec_t'(1));
   assign setbit = set_en ? (lvl_vec_t'(1) << set_lvl) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (eoi ? (isr_q & ~lowbit) : isr_q) | setbit;
   end

   assign ispr = isr_q;

   assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> isr_q[$past(set_lvl)]);
   assert_eoi_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !set_en && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int ADDR_W = 12,
   localparam int ID_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
   localparam int NBYTES = NSRC / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_i,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              int_ack,
   output logic              int_req,
   output logic [ID_W-1:0]   int_id
);
   if (NSRC % 8 != 0 || NSRC < 8 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("NSRC must be a multiple of 8 between 8 and 64");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NSRC-1:0]   ctrl_we, ack_clr, pend, mask;
   logic [NBYTES-1:0] win_we;
   prio_t             prio [NSRC];
   lvl_vec_t          ispr;
   logic              found, ack, eoi, isr_hit;
   logic [ID_W-1:0]   sel_id, id_q;
   logic              req_q;

   assign ack     = int_ack & req_q;
   assign eoi     = bus_we & (bus_addr == ADDR_W'(EOI_OFS));
   assign isr_hit = (bus_addr == ADDR_W'(ISR_OFS));

   for (genvar n = 0; n < NSRC; n++) begin : g_dec
      assign ctrl_we[n] = bus_we & (bus_addr == ADDR_W'(CTRL_OFS + 2*n));
      assign ack_clr[n] = ack & (id_q == ID_W'(n));
   end
   for (genvar b = 0; b < NBYTES; b++) begin : g_win
      assign win_we[b] = bus_we & (bus_addr == ADDR_W'(MASK_OFS + b));
   end

   prio_irq_srcbank #(.NSRC(NSRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ctrl_we(ctrl_we),
      .win_we(win_we), .wdata(bus_wdata), .ack_clr(ack_clr),
      .pend(pend), .mask(mask), .prio(prio)
   );

   prio_irq_arb #(.NSRC(NSRC)) u_arb (
      .pend(pend), .mask(mask), .prio(prio), .ispr(ispr),
      .found(found), .sel_id(sel_id)
   );

   prio_irq_isr u_isr (
      .clk(clk), .rst_n(rst_n), .set_en(ack), .set_lvl(prio[id_q]),
      .eoi(eoi), .ispr(ispr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         id_q  <= '0;
      end else begin
         req_q <= ack ? 1'b0 : found;
         id_q  <= ack ? id_q : sel_id;
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int n = 0; n < NSRC; n++) begin
         if (bus_addr == ADDR_W'(CTRL_OFS + 2*n))
            bus_rdata = {pend[n], mask[n], 3'b000, prio[n]};
      end
      for (int b = 0; b < NBYTES; b++) begin
         if (bus_addr == ADDR_W'(MASK_OFS + b))
            bus_rdata = mask[b*8 +: 8];
      end
      if (isr_hit) bus_rdata = ispr;
   end

   assign int_req = req_q;
   assign int_id  = id_q;

   assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !int_req);
   assert_isr_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && isr_hit && !ack) |=> $stable(ispr));
   assert_ack_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq_i[id_q]) |=> !pend[$past(id_q)]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
   localparam int NSRC = 64;
   localparam int ADDR_W = 12;
   localparam int ID_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   irq = '0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              int_ack = 1'b0;
   logic              int_req;
   logic [ID_W-1:0]   int_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .int_ack(int_ack), .int_req(int_req), .int_id(int_id)
   );

   function automatic logic [11:0] ctl(int n);
      return 12'(16'h110 + 2*n);
   endfunction

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic do_ack();
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic do_reset();
      irq = '0; bus_we = 1'b0; int_ack = 1'b0; rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      check("R1 int_req", int_req, 0);
      rd(ctl(0), d);  check("R1 ctrl src0", d, 8'h47);
      rd(ctl(63), d); check("R1 ctrl src63", d, 8'h47);
      rd(12'h107, d); check("R1 window byte7", d, 8'hFF);
      rd(12'h1FA, d); check("R1 isr", d, 8'h00);
   endtask

   task automatic t_latency();
      logic [7:0] d;
      do_reset();
      wr(ctl(3), 8'h02);
      rd(ctl(3), d); check("R2 ctrl layout", d, 8'h02);
      irq[3] = 1'b1;
      tick(1);
      rd(ctl(3), d); check("R2 pend bit7", d, 8'h82);
      check("R11 no req yet", int_req, 0);
      tick(1);
      check("R11 req after two edges", int_req, 1);
      check("R11 id", int_id, 3);
   endtask

   task automatic t_alias();
      logic [7:0] d;
      do_reset();
      wr(ctl(10), 8'h3B);
      rd(12'h101, d); check("R3 window sees ctrl", d, 8'hFB);
      rd(ctl(10), d); check("R2 bits5:3 read zero", d, 8'h03);
      wr(12'h101, 8'hFF);
      rd(ctl(10), d); check("R3 ctrl sees window", d, 8'h43);
      wr(12'h100, 8'h00);
      rd(ctl(7), d); check("R3 window clear", d, 8'h07);
      wr(12'h100, 8'hFF);
      rd(ctl(0), d); check("R3 window set all", d, 8'h47);
   endtask

   task automatic t_masked_pend();
      logic [7:0] d;
      do_reset();
      irq[5] = 1'b1;
      tick(2);
      rd(ctl(5), d); check("R4 masked pend latched", d, 8'hC7);
      check("R4 masked no req", int_req, 0);
      wr(12'h100, 8'hDF);
      tick(1);
      check("R4 delivered after unmask", int_req, 1);
      check("R4 id", int_id, 5);
   endtask

   task automatic t_swclear();
      logic [7:0] d;
      do_reset();
      irq[6] = 1'b1;
      tick(1);
      wr(ctl(6), 8'h47);
      rd(ctl(6), d); check("R5 sw clear", d, 8'h47);
      wr(ctl(6), 8'h84);
      rd(ctl(6), d); check("R5 write 1 no set", d, 8'h04);
      tick(1);
      check("R5 no req after clear", int_req, 0);
      irq[6] = 1'b0;
      tick(1);
      irq[6] = 1'b1;
      wr(ctl(6), 8'h44);
      rd(ctl(6), d); check("R5 edge beats clear", d, 8'hC4);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      do_reset();
      wr(ctl(2), 8'h05);
      wr(ctl(9), 8'h01);
      wr(ctl(11), 8'h01);
      irq[2] = 1'b1; irq[9] = 1'b1;
      tick(2);
      check("R6 urgent wins", int_id, 9);
      do_ack();
      check("R8 req dropped", int_req, 0);
      rd(12'h1FA, d); check("R8 isr set", d, 8'h02);
      rd(ctl(9), d); check("R8 pend cleared", d, 8'h01);
      irq[11] = 1'b1;
      tick(3);
      check("R7 equal and lower blocked", int_req, 0);
      wr(12'h1FA, 8'h00);
      rd(12'h1FA, d); check("R10 isr read-only", d, 8'h02);
      wr(ctl(7), 8'h00);
      irq[7] = 1'b1;
      tick(2);
      check("R7 preempt req", int_req, 1);
      check("R7 preempt id", int_id, 7);
      do_ack();
      rd(12'h1FA, d); check("R8 nested isr", d, 8'h03);
      wr(12'h1FC, 8'h00);
      rd(12'h1FA, d); check("R9 eoi lowest bit", d, 8'h02);
      tick(1);
      check("R7 still blocked", int_req, 0);
      wr(12'h1FC, 8'h00);
      tick(1);
      check("R6 tie after eoi id", int_id, 11);
      check("R9 unblocked req", int_req, 1);
   endtask

   task automatic t_tie();
      do_reset();
      wr(ctl(12), 8'h03);
      wr(ctl(4), 8'h03);
      irq[12] = 1'b1; irq[4] = 1'b1;
      tick(2);
      check("R6 tie lower index", int_id, 4);
   endtask

   task automatic t_ack_eoi();
      logic [7:0] d;
      do_reset();
      wr(ctl(20), 8'h04);
      irq[20] = 1'b1;
      tick(2);
      check("R6 single id", int_id, 20);
      do_ack();
      rd(12'h1FA, d); check("R8 isr lvl4", d, 8'h10);
      wr(ctl(33), 8'h01);
      irq[33] = 1'b1;
      tick(2);
      check("R7 preempt id", int_id, 33);
      int_ack = 1'b1;
      wr(12'h1FC, 8'h00);
      int_ack = 1'b0;
      rd(12'h1FA, d); check("R9 ack with eoi", d, 8'h02);
      wr(12'h1FC, 8'h00);
      rd(12'h1FA, d); check("R9 eoi to empty", d, 8'h00);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_alias();
      t_masked_pend();
      t_swclear();
      t_priority();
      t_tie();
      t_ack_eoi();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule